// File: doc/BRIEF.md
# Dual-Dataflow Convolution PE Grid

A rectangular grid of signed multiply-accumulate cells that computes one output tile of a convolution layer. A run-time mode input decides how operands travel through the grid. In systolic mode, every row receives one activation stream at its left edge, and the value hops one cell to the right each clock. A single fetched activation therefore meets the weight of every column, which suits pointwise and standard convolution (rows are output pixels, columns are output channels). In column-parallel mode, every column is an independent depthwise channel. Its activation stream enters at the top and hops one row down each clock, and its weight is broadcast down the column, so row r of a column produces the window that is shifted by r taps.

Multiplexers in front of each cell pick the left or the upper neighbour as the operand source. A per-column weight skew line aligns weights with the travelling activations, so the caller presents all lanes of one step in the same cycle. A clear input zeroes the accumulators. A start pulse launches a tile of `tile_len` steps, and a per-column valid strobe marks results that are complete. Results are read one grid row at a time through a row select.

Top module: `dfpe_grid`

## Requirements
- R1: After reset, `busy`, `mode_err` and every `col_valid` bit are 0, and every accumulator reads 0 at every `rd_row`.
- R2: With `mode_sel`=0 (systolic), the cell at row r, column c ends the tile holding the saturated sum over steps t<K of a_r(t)*w_c(t). Here a_r(t) is `row_act` lane r (bits r*8+:8) and w_c(t) is `col_wgt` lane c (bits c*8+:8). `col_act` has no effect in this mode.
- R3: With `mode_sel`=1 (column-parallel), the cell at row r, column c ends the tile holding the saturated sum over steps t<K of w_c(t)*b_c(t-r), where b_c is `col_act` lane c and b_c is taken as 0 at a negative index. `row_act` has no effect in this mode.
- R4: A `start` pulse seen while idle launches a tile of K=`tile_len` steps. The operands of step t are sampled t+1 cycles after the start cycle. Operands outside those K cycles are ignored. `busy` is high from the cycle after start through cycle K+COLS after start in systolic mode, and through cycle K+1 after start in column-parallel mode.
- R5: In systolic mode, `col_valid[c]` first reads 1 in cycle K+c+2 after the start cycle. In column-parallel mode, all columns first read 1 in cycle K+2 after the start cycle.
- R6: Accumulators are signed 24-bit and clamp at +8388607 and -8388608 instead of wrapping.
- R7: `acc_clr` zeroes all accumulators and all `col_valid` bits in the next cycle. A start without a preceding clear adds the new tile onto the held sums.
- R8: The active mode is taken from `mode_sel` only while idle. In every busy cycle where `mode_sel` differs from the active mode, `mode_err` is 1 in the following cycle, and the tile completes in its original mode.
- R9: A `start` pulse while `busy` is ignored: timing and results are unchanged.
- R10: While idle and without a clear, results and set `col_valid` bits hold, whatever the operand and mode inputs do.
- R11: `col_res` lane c (bits c*24+:24) shows the accumulator at row `rd_row`, column c, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel | input | 1 | 0 systolic, 1 column-parallel |
| start | input | 1 | Launch a tile when idle |
| acc_clr | input | 1 | Synchronous clear of accumulators and valid strobes |
| tile_len | input | LW | Steps K in the tile |
| row_act | input | ROWS*DW | Per-row activations (systolic) |
| col_act | input | COLS*DW | Per-column activations (column-parallel) |
| col_wgt | input | COLS*DW | Per-column weights |
| rd_row | input | RSW | Grid row shown on `col_res` |
| col_res | output | COLS*AW | Per-column accumulator of the selected row |
| col_valid | output | COLS | Per-column result complete |
| busy | output | 1 | Tile in progress |
| mode_err | output | 1 | Mode change attempted while busy |

## Verification
The hardest states to reach from the ports are the two clamping limits and a mid-tile disturbance. Reaching either limit takes more than 500 full-scale steps, so the stimulus runs two long tiles of constant extreme operands, one in each mode. For the disturbance, the stimulus flips `mode_sel` for exactly two busy cycles and, in another tile, pulses `start` with a different length in the middle of a run. In both cases it then checks `mode_err` in the correct cycles, the unchanged valid timing and exact sums. Junk operands are driven on every lane outside the issue window and on the unused activation input, so each dataflow also shows that it ignores them.

// File: rtl/dfpe_pkg.sv
package dfpe_pkg;
  typedef enum logic {
    DF_SYST = 1'b0,
    DF_COLP = 1'b1
  } df_mode_e;
endpackage

// File: rtl/dfpe_ctrl.sv
module dfpe_ctrl
  import dfpe_pkg::*;
#(
  parameter int COLS = 32,
  parameter int LW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            acc_clr,
  input  logic            mode_sel,
  input  logic [LW-1:0]   tile_len,
  output logic            busy,
  output logic            issue,
  output logic            flush,
  output df_mode_e        mode,
  output logic [COLS-1:0] col_valid,
  output logic            mode_err
);
  localparam int CW = LW + $clog2(COLS) + 1;

  logic            busy_q, busy_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [LW-1:0]   len_q, len_d;
  df_mode_e        mode_q, mode_d;
  logic [COLS-1:0] vld_q, vld_d;
  logic            err_q, err_d;
  logic            start_go;
  logic [CW-1:0]   len_x, fin_x;

  assign start_go = start && !busy_q;
  assign len_x    = CW'(len_q);
  assign fin_x    = (mode_q == DF_SYST) ? len_x + CW'(COLS - 1) : len_x;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    vld_d  = vld_q;
    mode_d = busy_q ? mode_q : df_mode_e'(mode_sel);
    err_d  = busy_q && (df_mode_e'(mode_sel) != mode_q);
    if (start_go) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      len_d  = tile_len;
      vld_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + CW'(1);
      for (int c = 0; c < COLS; c++) begin
        if (cnt_q == len_x + ((mode_q == DF_SYST) ? CW'(c) : CW'(0)))
          vld_d[c] = 1'b1;
      end
      if (cnt_q == fin_x) busy_d = 1'b0;
    end
    if (acc_clr && !start_go) vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
      mode_q <= DF_SYST;
      vld_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      mode_q <= mode_d;
      vld_q  <= vld_d;
      err_q  <= err_d;
    end
  end

  assign busy      = busy_q;
  assign issue     = busy_q && (cnt_q < len_x);
  assign flush     = start_go || acc_clr;
  assign mode      = mode_q;
  assign col_valid = vld_q;
  assign mode_err  = err_q;
endmodule

// File: rtl/dfpe_wskew.sv
module dfpe_wskew #(
  parameter int COLS = 32,
  parameter int DW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 issue,
  input  logic [COLS*DW-1:0]   w_in,
  output logic [COLS*DW-1:0]   w_syst,
  output logic [COLS*DW-1:0]   w_colp
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [DW-1:0] st_q [c+1];
    logic [DW-1:0] st_d [c+1];

    always_comb begin
      st_d[0] = (flush || !issue) ? '0 : w_in[c*DW +: DW];
      for (int k = 1; k <= c; k++) st_d[k] = flush ? '0 : st_q[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k <= c; k++) st_q[k] <= '0;
      end else begin
        for (int k = 0; k <= c; k++) st_q[k] <= st_d[k];
      end
    end

    assign w_syst[c*DW +: DW] = st_q[c];
    assign w_colp[c*DW +: DW] = st_q[0];
  end
endmodule

// File: rtl/dfpe_cell.sv
module dfpe_cell
  import dfpe_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          acc_clr,
  input  logic          acc_en,
  input  df_mode_e      mode,
  input  logic [DW-1:0] x_left,
  input  logic [DW-1:0] x_up,
  input  logic [DW-1:0] w_syst,
  input  logic [DW-1:0] w_colp,
  output logic [DW-1:0] x_out,
  output logic [AW-1:0] acc_out
);
  localparam int PW = 2 * DW;
  localparam logic [AW-1:0] ACC_MAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] ACC_MIN = {1'b1, {(AW-1){1'b0}}};

  logic [DW-1:0] x_q, x_d;
  logic [AW-1:0] acc_q, acc_d;
  logic [DW-1:0] w_use;
  logic signed [PW-1:0] prod;
  logic [AW:0] sum_w;
  logic [AW-1:0] sat_w;

  always_comb begin
    w_use = (mode == DF_COLP) ? w_colp : w_syst;
    prod  = $signed(x_q) * $signed(w_use);
    sum_w = {acc_q[AW-1], acc_q} + {{(AW+1-PW){prod[PW-1]}}, prod};
    if (sum_w[AW] != sum_w[AW-1]) sat_w = sum_w[AW] ? ACC_MIN : ACC_MAX;
    else                          sat_w = sum_w[AW-1:0];
    x_d = flush ? '0 : ((mode == DF_COLP) ? x_up : x_left);
    if (acc_clr)     acc_d = '0;
    else if (acc_en) acc_d = sat_w;
    else             acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      acc_q <= '0;
    end else begin
      x_q   <= x_d;
      acc_q <= acc_d;
    end
  end

  assign x_out   = x_q;
  assign acc_out = acc_q;
endmodule

// File: rtl/dfpe_grid.sv
module dfpe_grid
  import dfpe_pkg::*;
#(
  parameter int ROWS = 14,
  parameter int COLS = 32,
  parameter int DW   = 8,
  parameter int AW   = 24,
  parameter int LW   = 8,
  localparam int RSW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_sel,
  input  logic                 start,
  input  logic                 acc_clr,
  input  logic [LW-1:0]        tile_len,
  input  logic [ROWS*DW-1:0]   row_act,
  input  logic [COLS*DW-1:0]   col_act,
  input  logic [COLS*DW-1:0]   col_wgt,
  input  logic [RSW-1:0]       rd_row,
  output logic [COLS*AW-1:0]   col_res,
  output logic [COLS-1:0]      col_valid,
  output logic                 busy,
  output logic                 mode_err
);
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic     issue, flush;
  df_mode_e mode_act;
  logic [COLS*DW-1:0] w_syst, w_colp;

  dfpe_ctrl #(.COLS(COLS), .LW(LW)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start(start), .acc_clr(acc_clr),
    .mode_sel(mode_sel), .tile_len(tile_len), .busy(busy), .issue(issue),
    .flush(flush), .mode(mode_act), .col_valid(col_valid), .mode_err(mode_err)
  );

  dfpe_wskew #(.COLS(COLS), .DW(DW)) u_wskew (
    .clk(clk), .rst_n(rst_int_n), .flush(flush), .issue(issue),
    .w_in(col_wgt), .w_syst(w_syst), .w_colp(w_colp)
  );

  logic [DW-1:0] x_w   [ROWS][COLS];
  logic [AW-1:0] acc_w [ROWS][COLS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_cell
      logic [DW-1:0] left_v, up_v;
      if (c == 0) begin : g_lhead
        assign left_v = issue ? row_act[r*DW +: DW] : '0;
      end else begin : g_lchain
        assign left_v = x_w[r][c-1];
      end
      if (r == 0) begin : g_uhead
        assign up_v = issue ? col_act[c*DW +: DW] : '0;
      end else begin : g_uchain
        assign up_v = x_w[r-1][c];
      end
      dfpe_cell #(.DW(DW), .AW(AW)) u_cell (
        .clk(clk), .rst_n(rst_int_n), .flush(flush), .acc_clr(acc_clr),
        .acc_en(busy), .mode(mode_act), .x_left(left_v), .x_up(up_v),
        .w_syst(w_syst[c*DW +: DW]), .w_colp(w_colp[c*DW +: DW]),
        .x_out(x_w[r][c]), .acc_out(acc_w[r][c])
      );
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_rd
    always_comb begin
      col_res[c*AW +: AW] = '0;
      for (int r = 0; r < ROWS; r++) begin
        if (rd_row == RSW'(r)) col_res[c*AW +: AW] = acc_w[r][c];
      end
    end
  end
endmodule

// File: rtl/dfpe_grid_chk.sv
module dfpe_grid_chk #(
  parameter int ROWS = 14,
  parameter int COLS = 32,
  parameter int AW   = 24,
  localparam int RSW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               acc_clr,
  input logic               busy,
  input logic               mode_act,
  input logic               mode_err,
  input logic [COLS-1:0]    col_valid,
  input logic [RSW-1:0]     rd_row,
  input logic [COLS*AW-1:0] col_res
);
  AST_ERR_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> $past(busy)); // R8
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_act)); // R8
  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && col_valid == '0)); // R4
  AST_VALID_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    ((col_valid & (col_valid + 1'b1)) == '0)); // R5
  AST_COLP_ALL_OR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act && col_valid != '0) |-> (&col_valid)); // R5
  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (col_res == '0 && col_valid == '0)); // R7
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_clr && !(start && !busy)) |=> ((col_valid & $past(col_valid)) == $past(col_valid))); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!busy && !acc_clr) && $stable(rd_row)) |-> $stable(col_res)); // R10
endmodule

bind dfpe_grid dfpe_grid_chk #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .start(start), .acc_clr(acc_clr), .busy(busy),
  .mode_act(mode_act), .mode_err(mode_err), .col_valid(col_valid),
  .rd_row(rd_row), .col_res(col_res)
);

// File: tb/sim_dfpe_grid.sv
module sim_dfpe_grid;
  localparam int ROWS = 4;
  localparam int COLS = 6;
  localparam int DW   = 8;
  localparam int AW   = 24;
  localparam int LW   = 10;
  localparam int RSW  = $clog2(ROWS);
  localparam longint SMAX = 8388607;
  localparam longint SMIN = -8388608;
  // table: mode, steps, seed
  localparam int NT = 6;
  localparam int TBL [NT][3] = '{'{0, 1, 2}, '{0, 7, 5}, '{1, 1, 9},
                                 '{1, 6, 11}, '{0, 9, 17}, '{1, 12, 23}};

  logic clk, rst_n, mode_sel, start, acc_clr;
  logic [LW-1:0] tile_len;
  logic [ROWS*DW-1:0] row_act;
  logic [COLS*DW-1:0] col_act, col_wgt;
  logic [RSW-1:0] rd_row;
  logic [COLS*AW-1:0] col_res;
  logic [COLS-1:0] col_valid;
  logic busy, mode_err;

  int nchk = 0;
  int nerr = 0;
  int wd = 0;
  longint expv [ROWS][COLS];

  dfpe_grid #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .AW(AW), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .start(start), .acc_clr(acc_clr),
    .tile_len(tile_len), .row_act(row_act), .col_act(col_act), .col_wgt(col_wgt),
    .rd_row(rd_row), .col_res(col_res), .col_valid(col_valid), .busy(busy),
    .mode_err(mode_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      nchk++; nerr++;
      $display("FAIL all watchdog expired actual %0d expected %0d", wd, 0);
      report();
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int opv(int seed, int kind, int t, int i);
    int v;
    if (seed == 1000) return 127;
    if (seed == 1001) return (kind == 1) ? -128 : 127;
    v = ((seed * 37 + (t + 2) * 13 + i * 29 + kind * 101 + (t + 2) * i * 3 + t * t * 5) % 256 + 256) % 256;
    return v - 128;
  endfunction

  function automatic longint sat24(longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  task automatic drive_ops(input int seed, input int t);
    for (int r = 0; r < ROWS; r++) row_act[r*DW +: DW] = DW'(opv(seed, 0, t, r));
    for (int c = 0; c < COLS; c++) begin
      col_wgt[c*DW +: DW] = DW'(opv(seed, 1, t, c));
      col_act[c*DW +: DW] = DW'(opv(seed, 2, t, c));
    end
  endtask

  task automatic model_clear();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) expv[r][c] = 0;
  endtask

  task automatic model_tile(input int mode, input int k, input int seed);
    for (int t = 0; t < k; t++)
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          longint p;
          if (mode == 0) p = longint'(opv(seed, 0, t, r) * opv(seed, 1, t, c));
          else if (t >= r) p = longint'(opv(seed, 1, t, c) * opv(seed, 2, t - r, c));
          else p = 0;
          expv[r][c] = sat24(expv[r][c] + p);
        end
  endtask

  task automatic check_results(input string req);
    for (int r = 0; r < ROWS; r++) begin
      rd_row = RSW'(r);
      #1;
      for (int c = 0; c < COLS; c++)
        chk(req, $sformatf("acc row %0d lane %0d (R11 read)", r, c),
            longint'($signed(col_res[c*AW +: AW])), expv[r][c]);
    end
  endtask

  // flags: bit0 keep sums (no clear), bit1 flip mode mid-tile, bit2 start pulse mid-tile
  task automatic run_tile(input int mode, input int k, input int seed, input int flags, input string req);
    int vbad = 0, bbad = 0, ebad = 0;
    int last_n;
    if (!flags[0]) begin
      acc_clr = 1'b1;
      @(negedge clk);
      acc_clr = 1'b0;
      model_clear();
    end
    mode_sel = (mode != 0);
    tile_len = LW'(k);
    start = 1'b1;
    drive_ops(seed, -1);
    @(negedge clk);
    start = 1'b0;
    last_n = k + COLS + 3;
    for (int n = 1; n <= last_n; n++) begin
      logic [COLS-1:0] ev;
      logic eb, ee;
      eb = (mode != 0) ? (n <= k + 1) : (n <= k + COLS);
      for (int c = 0; c < COLS; c++) ev[c] = (n >= k + 2 + ((mode != 0) ? 0 : c));
      ee = flags[1] && (n == 4 || n == 5);
      if (col_valid != ev) vbad++;
      if (busy != eb) bbad++;
      if (mode_err != ee) ebad++;
      drive_ops(seed, n - 1);
      if (flags[1]) begin
        if (n == 3) mode_sel = (mode == 0);
        if (n == 5) mode_sel = (mode != 0);
      end
      if (flags[2]) begin
        start = (n == 4);
        tile_len = (n == 4) ? LW'(1) : LW'(k);
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk("R5", "cycles with wrong valid pattern", vbad, 0);
    chk("R4", "cycles with wrong busy level", bbad, 0);
    chk("R8", "cycles with wrong mode_err level", ebad, 0);
    model_tile(mode, k, seed);
    check_results(req);
  endtask

  initial begin
    rst_n = 1'b1; mode_sel = 1'b0; start = 1'b0; acc_clr = 1'b0;
    tile_len = '0; row_act = '0; col_act = '0; col_wgt = '0; rd_row = '0;
    #5 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "col_valid after reset", col_valid, 0);
    chk("R1", "mode_err after reset", mode_err, 0);
    model_clear();
    check_results("R1");

    // vector table walk: R2 systolic, R3 column-parallel
    for (int i = 0; i < NT; i++)
      run_tile(TBL[i][0], TBL[i][1], TBL[i][2], 0, (TBL[i][0] == 0) ? "R2" : "R3");

    // R7 continuation without clear, then clear
    @(negedge clk);
    run_tile(0, 4, 31, 0, "R2");
    run_tile(0, 3, 41, 1, "R7");
    acc_clr = 1'b1;
    @(negedge clk);
    acc_clr = 1'b0;
    model_clear();
    chk("R7", "col_valid after clear", col_valid, 0);
    check_results("R7");

    // R8 mode flipped for two busy cycles: ignored and flagged
    @(negedge clk);
    run_tile(0, 5, 53, 2, "R8");

    // R9 start while busy ignored
    @(negedge clk);
    run_tile(1, 6, 59, 4, "R9");

    // R10 idle hold under toggling inputs
    for (int i = 0; i < 6; i++) begin
      drive_ops(77, i);
      mode_sel = i[0];
      @(negedge clk);
      chk("R10", "idle mode_err", mode_err, 0);
      chk("R10", "idle col_valid", col_valid, {COLS{1'b1}});
    end
    mode_sel = 1'b0;
    check_results("R10");

    // R6 saturation at both limits
    @(negedge clk);
    run_tile(0, 600, 1000, 0, "R6");
    rd_row = '0; #1;
    chk("R6", "positive clamp", longint'($signed(col_res[0 +: AW])), SMAX);
    @(negedge clk);
    run_tile(1, 600, 1001, 0, "R6");
    rd_row = RSW'(ROWS - 1); #1;
    chk("R6", "negative clamp", longint'($signed(col_res[(COLS-1)*AW +: AW])), SMIN);

    report();
    $finish;
  end
endmodule